// File: doc/BRIEF.md
# Destination Address Filter for a Receive Byte Stream

This block sits beside a receive path that delivers frame bytes one per clock enable. While the first six bytes of a frame go by, it compares them against a configured 48-bit station address. It also notes the group bit of the first byte. Payload bytes after the address pass by without effect. When the frame closes, the address verdict is merged with the frame-check status supplied by the receiver. The result is exactly one single-cycle pulse: either deliver or drop.

Three kinds of destination are accepted: the exact station address, any group address (the broadcast address is one of these), and, when promiscuous mode is on, any destination at all. A frame whose check status is bad is always dropped. A frame that closes before its full address has arrived is dropped unless promiscuous mode is on.

Top module: `dst_addr_filter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, both `deliver` and `drop` are low.
- R2: A good frame with at least six bytes, whose bytes 0..5 equal `local_mac[47:40]`, `[39:32]`, ... `[7:0]` in that order of arrival, produces a `deliver` pulse.
- R3: If any one of the six address bytes differs from the matching byte of `local_mac`, and bit 0 of byte 0 is 0, a good frame produces a `drop` pulse while promiscuous mode is off.
- R4: A good frame with at least six bytes whose byte 0 has bit 0 set to 1 is delivered. This covers every group address, including FF:FF:FF:FF:FF:FF.
- R5: With `promisc_en` high, every good frame is delivered, whatever its destination and even if it has fewer than six bytes.
- R6: A frame closed with `rx_good` low is dropped, whatever its address and the mode.
- R7: With promiscuous mode off, a frame that closes after fewer than six bytes is dropped, even if the bytes that did arrive match.
- R8: Each `rx_end` produces exactly one of `deliver` or `drop`, high for one cycle, in the cycle after `rx_end`. Neither output is high at any other time.
- R9: `rx_start` discards all address state left over from an earlier frame, including an unfinished one.
- R10: Bytes after the sixth do not affect the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| promisc_en | input | 1 | Accept every good frame when high |
| local_mac | input | 48 | Station address; bits 47:40 are the first byte on the wire |
| rx_start | input | 1 | One-cycle pulse before the first byte of a frame; carries no byte |
| rx_vld | input | 1 | `rx_byte` holds a frame byte this cycle |
| rx_byte | input | 8 | Frame byte |
| rx_end | input | 1 | One-cycle pulse after the last byte; carries no byte |
| rx_good | input | 1 | Frame-check status, sampled with `rx_end` |
| deliver | output | 1 | One-cycle pulse: the frame is kept |
| drop | output | 1 | One-cycle pulse: the frame is discarded |

## Verification
The bench builds the block with its default parameters: six address bytes of eight bits. With these values the real 48-bit compare, the byte-0 group bit and the saturating byte counter are all exercised with ordinary addresses. This brings the mismatch positions at the first, a middle and the last byte within reach, as well as frames that close at four, five, three and exactly six bytes. Frames abandoned without an end pulse are used to show that a new start clears the leftover state.

// File: rtl/mac_filt_pkg.sv
package mac_filt_pkg;
  localparam int unsigned OCTET_W   = 8;
  localparam int unsigned ADDR_OCTS = 6;
  typedef logic [OCTET_W-1:0] octet_t;
endpackage

// File: rtl/addr_octet_counter.sv
module addr_octet_counter #(
  parameter int unsigned NUM_OCTS = 6,
  localparam int unsigned CNT_W   = $clog2(NUM_OCTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_start,
  input  logic             rx_vld,
  output logic [CNT_W-1:0] oct_idx,
  output logic             in_addr,
  output logic             addr_done
);
  logic [CNT_W-1:0] idx_q, idx_d;
  logic             idx_en;

  assign in_addr   = (idx_q < CNT_W'(NUM_OCTS));
  assign addr_done = (idx_q == CNT_W'(NUM_OCTS));
  assign oct_idx   = idx_q;

  always_comb begin
    idx_en = 1'b0;
    idx_d  = idx_q;
    if (rx_start) begin
      idx_en = 1'b1;
      idx_d  = '0;
    end else if (rx_vld && in_addr) begin
      idx_en = 1'b1;
      idx_d  = idx_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end
endmodule

// File: rtl/addr_octet_matcher.sv
module addr_octet_matcher
  import mac_filt_pkg::*;
#(
  parameter int unsigned NUM_OCTS = 6,
  localparam int unsigned ADDR_W  = NUM_OCTS * OCTET_W,
  localparam int unsigned CNT_W   = $clog2(NUM_OCTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_start,
  input  logic              rx_vld,
  input  octet_t            rx_byte,
  input  logic [ADDR_W-1:0] local_mac,
  input  logic [CNT_W-1:0]  oct_idx,
  input  logic              in_addr,
  output logic              uni_hit,
  output logic              grp_hit
);
  octet_t exp_oct [NUM_OCTS];
  octet_t exp_sel;

  // Byte i on the wire is compared with the i-th most significant octet.
  for (genvar g = 0; g < NUM_OCTS; g++) begin : g_oct
    assign exp_oct[g] = local_mac[ADDR_W-1-g*OCTET_W -: OCTET_W];
  end

  always_comb begin
    exp_sel = '0;
    for (int i = 0; i < NUM_OCTS; i++)
      if (oct_idx == CNT_W'(i)) exp_sel = exp_oct[i];
  end

  logic uni_q, uni_d, grp_q, grp_d, st_en;

  always_comb begin
    st_en = 1'b0;
    uni_d = uni_q;
    grp_d = grp_q;
    if (rx_start) begin
      st_en = 1'b1;
      uni_d = 1'b1;
      grp_d = 1'b0;
    end else if (rx_vld && in_addr) begin
      st_en = 1'b1;
      uni_d = uni_q & (rx_byte == exp_sel);
      if (oct_idx == '0) grp_d = rx_byte[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uni_q <= 1'b1;
      grp_q <= 1'b0;
    end else if (st_en) begin
      uni_q <= uni_d;
      grp_q <= grp_d;
    end
  end

  assign uni_hit = uni_q;
  assign grp_hit = grp_q;
endmodule

// File: rtl/filt_verdict.sv
module filt_verdict (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_end,
  input  logic rx_good,
  input  logic promisc_en,
  input  logic addr_done,
  input  logic uni_hit,
  input  logic grp_hit,
  output logic deliver,
  output logic drop
);
  logic accept, dlv_d, drp_d, dlv_q, drp_q;

  always_comb begin
    accept = promisc_en | (addr_done & (uni_hit | grp_hit));
    dlv_d  = rx_end & rx_good & accept;
    drp_d  = rx_end & ~(rx_good & accept);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlv_q <= 1'b0;
      drp_q <= 1'b0;
    end else begin
      dlv_q <= dlv_d;
      drp_q <= drp_d;
    end
  end

  assign deliver = dlv_q;
  assign drop    = drp_q;
endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
  import mac_filt_pkg::*;
#(
  parameter int unsigned NUM_OCTS = ADDR_OCTS,
  localparam int unsigned ADDR_W  = NUM_OCTS * OCTET_W,
  localparam int unsigned CNT_W   = $clog2(NUM_OCTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              promisc_en,
  input  logic [ADDR_W-1:0] local_mac,
  input  logic              rx_start,
  input  logic              rx_vld,
  input  logic [7:0]        rx_byte,
  input  logic              rx_end,
  input  logic              rx_good,
  output logic              deliver,
  output logic              drop
);
  logic [CNT_W-1:0] oct_idx;
  logic             in_addr, addr_done, uni_hit, grp_hit;

  addr_octet_counter #(.NUM_OCTS(NUM_OCTS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .rx_vld(rx_vld),
    .oct_idx(oct_idx), .in_addr(in_addr), .addr_done(addr_done)
  );

  addr_octet_matcher #(.NUM_OCTS(NUM_OCTS)) u_match (
    .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .rx_vld(rx_vld),
    .rx_byte(rx_byte), .local_mac(local_mac), .oct_idx(oct_idx),
    .in_addr(in_addr), .uni_hit(uni_hit), .grp_hit(grp_hit)
  );

  filt_verdict u_verdict (
    .clk(clk), .rst_n(rst_n), .rx_end(rx_end), .rx_good(rx_good),
    .promisc_en(promisc_en), .addr_done(addr_done), .uni_hit(uni_hit),
    .grp_hit(grp_hit), .deliver(deliver), .drop(drop)
  );
endmodule

// File: rtl/dst_addr_filter_chk.sv
module dst_addr_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic promisc_en,
  input logic rx_end,
  input logic rx_good,
  input logic deliver,
  input logic drop
);
  // R8
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_end |=> $onehot({deliver, drop}));
  // R8
  deliver_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deliver |-> $past(rx_end));
  // R8
  drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> $past(rx_end));
  // R6
  bad_check_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_end && !rx_good) |=> drop);
  // R5
  promisc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_end && rx_good && promisc_en) |=> deliver);
endmodule

bind dst_addr_filter dst_addr_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .promisc_en(promisc_en), .rx_end(rx_end),
  .rx_good(rx_good), .deliver(deliver), .drop(drop)
);

// File: tb/dst_addr_filter_bench.sv
module dst_addr_filter_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [47:0] STATION = 48'h02_12_34_56_78_9A;
  localparam logic [47:0] BCAST   = 48'hFF_FF_FF_FF_FF_FF;
  localparam int NV = 13;
  // fields: address(48) byte count(4) promisc(1) good(1) expect deliver(1) requirement(4)
  localparam logic [58:0] VEC [NV] = '{
    {STATION,                4'd10, 1'b0, 1'b1, 1'b1, 4'd2},  // R2
    {48'h04_12_34_56_78_9A,  4'd10, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 first byte
    {48'h02_12_34_56_78_9B,  4'd10, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 last byte
    {48'h02_12_34_57_78_9A,  4'd10, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 middle byte
    {BCAST,                  4'd10, 1'b0, 1'b1, 1'b1, 4'd4},  // R4 broadcast
    {48'h01_00_5E_00_00_01,  4'd10, 1'b0, 1'b1, 1'b1, 4'd4},  // R4 group
    {48'h04_12_34_56_78_9A,  4'd10, 1'b1, 1'b1, 1'b1, 4'd5},  // R5
    {STATION,                4'd10, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
    {BCAST,                  4'd10, 1'b1, 1'b0, 1'b0, 4'd6},  // R6
    {STATION,                4'd4,  1'b0, 1'b1, 1'b0, 4'd7},  // R7
    {BCAST,                  4'd5,  1'b0, 1'b1, 1'b0, 4'd7},  // R7
    {48'h04_00_00_00_00_00,  4'd3,  1'b1, 1'b1, 1'b1, 4'd5},  // R5 short
    {STATION,                4'd6,  1'b0, 1'b1, 1'b1, 4'd2}   // R2 exactly six
  };

  logic clk = 1'b0, rst_n = 1'b0, promisc_en = 1'b0;
  logic [47:0] local_mac = STATION;
  logic rx_start = 1'b0, rx_vld = 1'b0, rx_end = 1'b0, rx_good = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic deliver, drop;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dst_addr_filter u_dst_addr_filter (
    .clk(clk), .rst_n(rst_n), .promisc_en(promisc_en), .local_mac(local_mac),
    .rx_start(rx_start), .rx_vld(rx_vld), .rx_byte(rx_byte), .rx_end(rx_end),
    .rx_good(rx_good), .deliver(deliver), .drop(drop)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {deliver,drop} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic send_bytes(input logic [47:0] a, input int n);
    @(negedge clk) rx_start = 1'b1;
    @(negedge clk) rx_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      rx_vld  = 1'b1;
      rx_byte = (i < 6) ? a[47-8*i -: 8] : 8'h3C;
      @(negedge clk);
    end
    rx_vld = 1'b0;
  endtask

  task automatic close_frame(input string req, input logic good, input logic exp_dlv);
    rx_end = 1'b1; rx_good = good;
    @(negedge clk);
    rx_end = 1'b0; rx_good = 1'b0;
    check(req, {deliver, drop}, {exp_dlv, ~exp_dlv});
    @(negedge clk);
    check("R8 pulse width", {deliver, drop}, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", {deliver, drop}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {deliver, drop}, 2'b00);

    for (int v = 0; v < NV; v++) begin
      promisc_en = VEC[v][6];
      send_bytes(VEC[v][58:11], int'(VEC[v][10:7]));
      close_frame($sformatf("R%0d vector %0d", VEC[v][3:0], v), VEC[v][5], VEC[v][4]);
    end
    promisc_en = 1'b0;

    // R9: abandoned mismatching frame, then a clean station frame
    send_bytes(48'h04_00_00_00_00_00, 3);
    send_bytes(STATION, 8);
    close_frame("R9 start clears mismatch", 1'b1, 1'b1);
    // R9: abandoned group frame must not leak into a short frame
    send_bytes(BCAST, 6);
    send_bytes(48'h02_00_00_00_00_00, 2);
    close_frame("R9 start clears group bit", 1'b1, 1'b0);

    // R10: many payload bytes after a matching address
    send_bytes(STATION, 15);
    close_frame("R10 payload ignored", 1'b1, 1'b1);

    // R1: reset asserted mid-run clears outputs
    send_bytes(STATION, 7);
    rx_end = 1'b1; rx_good = 1'b1;
    #1 rst_n = 1'b0;
    @(negedge clk);
    rx_end = 1'b0;
    check("R1 reset mid-run", {deliver, drop}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule